// File: doc/BRIEF.md
# UART Command to I2C Register Bridge

The bridge sits between a byte-wide UART receiver/transmitter pair and a two-wire I2C bus. A host sends short commands as bytes; the bridge turns them into register reads and writes on one I2C slave at a fixed 7-bit device address and returns the results as bytes. A read command is a header byte followed by one register index. A write command is a header byte followed by a register index and a data byte. The bridge acknowledges each header at once with a lowercase copy of it.

After every write the bridge reads the same register back and returns the value it got, so the host can compare it with what it sent. The I2C side is an open-drain master. Each output is an enable that pulls its line low. SCL is made from the system clock through a parameterized divider, and each bus bit is split into four quarter-periods of `DIV` clocks each. A slave that does not acknowledge a byte ends the transaction with a stop condition, and the host then receives an error byte in place of data.

Top module: `uart_i2c_bridge`

## Requirements
- R1: Accepting the header 0x52 ('R') in the idle state drives `tx_valid` high on the next cycle with `tx_data` = 0x72 ('r').
- R2: Accepting the header 0x57 ('W') in the idle state drives `tx_valid` high on the next cycle with `tx_data` = 0x77 ('w').
- R3: After 'R' the next byte is a register index. The bus then carries, in order: start, device byte (address<<1 | 0), index, repeated start, device byte (address<<1 | 1), 8 bits read MSB first, a released (NACK) ninth bit, and stop. Exactly 39 SCL rising edges occur, and the byte read is sent to the host.
- R4: After 'W' the next two bytes are index and data. The bus carries start, device byte with bit0=0, index, data, stop (29 SCL rising edges), and then the full R3 read of the same index. The byte read back is returned to the host.
- R5: A byte other than 0x52 or 0x57 received while idle is consumed and dropped. It produces no transmit byte and no bus activity, and the parser stays idle.
- R6: If SDA is high during the acknowledge bit of any byte the master writes, the bridge issues a stop at once, performs no further byte transfers, and returns 0x21 ('!') to the host instead of data.
- R7: While SCL is high the master changes SDA only to form a start (SDA falling) or a stop (SDA rising). Each command produces one start per transaction plus one repeated start per read, and one stop per transaction.
- R8: Within a byte, SCL is high for 2*DIV clocks and low for 2*DIV clocks.
- R9: `tx_data` holds steady while `tx_valid` is high and `tx_ready` low. Every produced byte is delivered once and in order, even when a new byte is produced in the same cycle the previous one is taken.
- R10: `rx_ready` is high only while the parser waits for a command byte; both bus lines are released whenever it is high.
- R11: After reset, `tx_valid`, `scl_oe` and `sda_oe` are low and `rx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Bridge takes the received byte this cycle |
| tx_valid | output | 1 | Byte waiting for the transmitter |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter takes the byte this cycle |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
Two things can happen in the same cycle: the transmitter takes a pending reply byte, and the parser accepts the next header and loads its echo into the same one-byte output slot. The bench provokes this by throttling `tx_ready` to one cycle in three while sending two read commands back to back. The second header then waits until the first reply is taken, and its acceptance lines up with that handshake. The result is judged by the four bytes the host receives, which must be the two echoes and the two register values in order, with none lost or doubled.

// File: rtl/uart_i2c_bridge.sv
module uart_i2c_bridge #(
  parameter int         DIV      = 4,
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);

  localparam int         DW       = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [7:0] HDR_RD   = 8'h52;
  localparam logic [7:0] HDR_WR   = 8'h57;
  localparam logic [7:0] ECHO_RD  = 8'h72;
  localparam logic [7:0] ECHO_WR  = 8'h77;
  localparam logic [7:0] ERR_BYTE = 8'h21;
  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_STOP  = 2'd1;
  localparam logic [1:0] OP_WB    = 2'd2;
  localparam logic [1:0] OP_RB    = 2'd3;
  localparam logic [3:0] STP_RD   = 4'd5;
  localparam logic [3:0] STP_LAST = 4'd11;

  typedef enum logic [2:0] {S_IDLE, S_RA, S_WA, S_WD, S_GO, S_WAIT, S_REPLY} st_t;

  st_t         st;
  logic [3:0]  stp;
  logic [7:0]  reg_a, reg_d;
  logic        err;
  logic [1:0]  cur_op, op;
  logic [7:0]  cur_byte;
  logic        busy, op_done, ack_ok;
  logic [3:0]  bitn;
  logic [1:0]  q;
  logic [7:0]  sh;
  logic [DW-1:0] div_cnt;

  wire tick    = busy && (div_cnt == '0);
  wire go      = (st == S_GO);
  wire tx_free = !tx_valid || tx_ready;
  wire rx_fire = rx_valid && rx_ready;

  always_comb begin
    case (st)
      S_IDLE:           rx_ready = tx_free;
      S_RA, S_WA, S_WD: rx_ready = 1'b1;
      default:          rx_ready = 1'b0;
    endcase
  end

  // step list: 0..4 write transaction, 5..11 read transaction
  always_comb begin
    cur_op   = OP_WB;
    cur_byte = reg_a;
    case (stp)
      4'd0, 4'd5, 4'd8: cur_op = OP_START;
      4'd4, 4'd11:      cur_op = OP_STOP;
      4'd10:            cur_op = OP_RB;
      4'd1, 4'd6:       cur_byte = {DEV_ADDR, 1'b0};
      4'd9:             cur_byte = {DEV_ADDR, 1'b1};
      4'd3:             cur_byte = reg_d;
      default:          cur_byte = reg_a;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      stp      <= '0;
      reg_a    <= '0;
      reg_d    <= '0;
      err      <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      case (st)
        S_IDLE: if (rx_fire) begin
          if (rx_data == HDR_RD) begin
            tx_valid <= 1'b1;
            tx_data  <= ECHO_RD;
            st       <= S_RA;
          end else if (rx_data == HDR_WR) begin
            tx_valid <= 1'b1;
            tx_data  <= ECHO_WR;
            st       <= S_WA;
          end
        end
        S_RA: if (rx_valid) begin
          reg_a <= rx_data;
          stp   <= STP_RD;
          err   <= 1'b0;
          st    <= S_GO;
        end
        S_WA: if (rx_valid) begin
          reg_a <= rx_data;
          st    <= S_WD;
        end
        S_WD: if (rx_valid) begin
          reg_d <= rx_data;
          stp   <= '0;
          err   <= 1'b0;
          st    <= S_GO;
        end
        S_GO: st <= S_WAIT;
        S_WAIT: if (op_done) begin
          if (stp == STP_LAST) begin
            st <= S_REPLY;
          end else if (op == OP_WB && !ack_ok) begin
            err <= 1'b1;
            stp <= STP_LAST;
            st  <= S_GO;
          end else begin
            stp <= stp + 4'd1;
            st  <= S_GO;
          end
        end
        S_REPLY: if (tx_free) begin
          tx_valid <= 1'b1;
          tx_data  <= err ? ERR_BYTE : sh;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // bit engine: each bit is four quarters; SCL low in q0/q1, high in q2/q3
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      op_done <= 1'b0;
      ack_ok  <= 1'b0;
      op      <= OP_START;
      bitn    <= '0;
      q       <= '0;
      sh      <= '0;
      div_cnt <= '0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      op_done <= 1'b0;
      if (go) begin
        busy    <= 1'b1;
        op      <= cur_op;
        bitn    <= '0;
        q       <= '0;
        div_cnt <= DW'(DIV - 1);
        scl_oe  <= 1'b1;
        if (cur_op == OP_WB) sh <= cur_byte;
      end else if (busy) begin
        if (!tick) begin
          div_cnt <= div_cnt - 1'b1;
        end else begin
          div_cnt <= DW'(DIV - 1);
          if (q == 2'd2) begin
            if (bitn == 4'd8) ack_ok <= !sda_in;
            else if (op == OP_RB) sh <= {sh[6:0], sda_in};
          end
          if (q == 2'd3) begin
            if (op == OP_START || op == OP_STOP || bitn == 4'd8) begin
              busy    <= 1'b0;
              op_done <= 1'b1;
            end else begin
              bitn   <= bitn + 4'd1;
              q      <= 2'd0;
              scl_oe <= 1'b1;
              if (op == OP_WB) sh <= {sh[6:0], 1'b0};
            end
          end else begin
            q <= q + 2'd1;
            case (q)
              2'd0: begin
                case (op)
                  OP_START: sda_oe <= 1'b0;
                  OP_STOP:  sda_oe <= 1'b1;
                  OP_WB:    sda_oe <= (bitn != 4'd8) && !sh[7];
                  default:  sda_oe <= 1'b0;
                endcase
              end
              2'd1: scl_oe <= 1'b0;
              default: begin
                if (op == OP_START)     sda_oe <= 1'b1;
                else if (op == OP_STOP) sda_oe <= 1'b0;
              end
            endcase
          end
        end
      end
    end
  end

  AST_RD_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && rx_fire && rx_data == HDR_RD) |=> (tx_valid && tx_data == ECHO_RD))
    else $error("read echo missing"); // R1
  AST_WR_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && rx_fire && rx_data == HDR_WR) |=> (tx_valid && tx_data == ECHO_WR))
    else $error("write echo missing"); // R2
  AST_ABORT_TO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && op_done && op == OP_WB && !ack_ok) |=> (stp == STP_LAST && err))
    else $error("nack did not abort"); // R6
  AST_SDA_HELD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && sda_oe != $past(sda_oe)) |-> (op == OP_START || op == OP_STOP))
    else $error("sda moved while scl high"); // R7
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)))
    else $error("tx byte dropped or changed"); // R9
  AST_BUS_FREE_PARSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (!scl_oe && !sda_oe))
    else $error("bus held while parsing"); // R10
  AST_NO_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy)
    else $error("op launched while busy"); // R7

endmodule

// File: tb/uart_i2c_bridge_tb.sv
module uart_i2c_bridge_tb;
  localparam int         CLK_PERIOD = 10;
  localparam int         DIV        = 2;
  localparam logic [6:0] DEV        = 7'h2C;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_ready;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b1;
  logic       scl_oe, sda_oe, sda_in;
  logic       s_oe;

  wire scl = !scl_oe;
  wire sda = !(sda_oe || s_oe);
  assign sda_in = sda;

  uart_i2c_bridge #(.DIV(DIV), .DEV_ADDR(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;
  int stall = 0;
  int nack_at = -1;
  bit timed_out = 1'b0;

  function automatic logic [7:0] init_val(input int a);
    return 8'((a * 37 + 5) % 256);
  endfunction

  // host-side transmit collector and ready throttle
  int         cyc = 0;
  int         txn = 0;
  logic [7:0] txbuf [256];
  always @(negedge clk) begin
    cyc = cyc + 1;
    tx_ready = (stall != 0) ? ((cyc % 3) == 0) : 1'b1;
    if (rst_n && tx_valid && tx_ready && txn < 256) begin
      txbuf[txn] = tx_data;
      txn = txn + 1;
    end
  end

  // I2C slave model and bus monitor
  logic [7:0] mem [256];
  logic       pscl, psda, ackph;
  int         mode, bcnt, bidx, tcnt;
  logic [7:0] rsh, ptr, tsh;
  int n_start, n_stop, n_rise, hi_run, lo_run, min_hi, min_lo;
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      pscl <= 1'b1; psda <= 1'b1; s_oe <= 1'b0; ackph <= 1'b0;
      mode <= 0; bcnt <= 0; bidx <= 0; tcnt <= 0;
      rsh <= '0; ptr <= '0; tsh <= '0;
      n_start <= 0; n_stop <= 0; n_rise <= 0;
      hi_run <= 0; lo_run <= 0; min_hi <= 1000; min_lo <= 1000;
    end else begin
      pscl <= scl;
      psda <= sda;
      if (scl && !pscl) begin
        if (lo_run < min_lo) min_lo <= lo_run;
        lo_run <= 0; hi_run <= 1;
      end else if (!scl && pscl) begin
        if (hi_run < min_hi) min_hi <= hi_run;
        hi_run <= 0; lo_run <= 1;
      end else if (scl) hi_run <= hi_run + 1;
      else lo_run <= lo_run + 1;

      if (scl && pscl && psda && !sda) begin
        n_start <= n_start + 1;
        mode <= 1; bcnt <= 0; bidx <= 0; ackph <= 1'b0; s_oe <= 1'b0;
      end else if (scl && pscl && !psda && sda) begin
        n_stop <= n_stop + 1;
        mode <= 0; s_oe <= 1'b0;
      end else if (scl && !pscl) begin
        n_rise <= n_rise + 1;
        if (mode == 1 && !ackph && bcnt < 8) begin
          rsh <= {rsh[6:0], sda};
          bcnt <= bcnt + 1;
        end
      end else if (!scl && pscl) begin
        if (mode == 1) begin
          if (ackph) begin
            s_oe <= 1'b0; ackph <= 1'b0; bcnt <= 0; bidx <= bidx + 1;
            if (bidx == 0) begin
              if (rsh[0]) begin
                mode <= 2; tsh <= mem[ptr]; s_oe <= !mem[ptr][7]; tcnt <= 1;
              end
            end else if (bidx == 1) ptr <= rsh;
            else mem[ptr] <= rsh;
          end else if (bcnt == 8) begin
            if (bidx == nack_at || (bidx == 0 && rsh[7:1] != DEV)) begin
              mode <= 0; s_oe <= 1'b0;
            end else begin
              s_oe <= 1'b1; ackph <= 1'b1;
            end
          end
        end else if (mode == 2) begin
          if (tcnt < 8) begin
            s_oe <= !tsh[7 - tcnt];
            tcnt <= tcnt + 1;
          end else begin
            s_oe <= 1'b0; mode <= 0;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    #1;
    while (!rx_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic run_cmd(input bit wr, input logic [7:0] a, input logic [7:0] d,
                         input logic [7:0] exp_reply, input int e_st, input int e_sp,
                         input int e_rise, input string rq);
    int t0, s0, p0, r0;
    t0 = txn; s0 = n_start; p0 = n_stop; r0 = n_rise;
    send_byte(wr ? 8'h57 : 8'h52);
    send_byte(a);
    if (wr) send_byte(d);
    while (txn < t0 + 2) @(negedge clk);
    repeat (6) @(negedge clk);
    if (wr) chk(txbuf[t0] == 8'h77, "R2", int'(txbuf[t0]), 8'h77);
    else    chk(txbuf[t0] == 8'h72, "R1", int'(txbuf[t0]), 8'h72);
    chk(txbuf[t0+1] == exp_reply, rq, int'(txbuf[t0+1]), int'(exp_reply));
    chk(txn == t0 + 2, "R9", txn - t0, 2);
    chk(n_start - s0 == e_st, "R7", n_start - s0, e_st);
    chk(n_stop - p0 == e_sp, "R7", n_stop - p0, e_sp);
    chk(n_rise - r0 == e_rise, rq, n_rise - r0, e_rise);
    chk(!scl_oe && !sda_oe && rx_ready, "R10", {scl_oe, sda_oe, rx_ready}, 1);
  endtask

  initial begin
    rx_valid = 1'b0;
    rx_data  = '0;
    rst_n    = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!tx_valid, "R11", tx_valid, 0);
    chk(!scl_oe && !sda_oe, "R11", {scl_oe, sda_oe}, 0);
    chk(rx_ready, "R11", rx_ready, 1);

    fork
      begin
        // R3: register reads across many indices, alternating a throttled transmitter
        for (int i = 0; i < 24; i++) begin
          stall = i % 2;
          run_cmd(1'b0, 8'(i * 11), 8'h00, init_val(i * 11), 2, 1, 39, "R3");
        end
        stall = 0;
        // R4: write then read-back
        for (int i = 0; i < 16; i++) begin
          logic [7:0] a, d;
          a = 8'(i * 16 + 3);
          d = 8'(i * 29 + 101);
          stall = i % 2;
          run_cmd(1'b1, a, d, d, 3, 2, 68, "R4");
          chk(mem[a] == d, "R4", int'(mem[a]), int'(d));
        end
        stall = 0;
        run_cmd(1'b0, 8'd35, 8'h00, 8'(2 * 29 + 101), 2, 1, 39, "R4");

        // R5: every non-header byte is dropped while idle
        for (int b = 0; b < 256; b++) begin
          int t0, r0;
          if (b == 8'h52 || b == 8'h57) continue;
          t0 = txn; r0 = n_rise;
          send_byte(8'(b));
          repeat (6) @(negedge clk);
          chk(txn == t0 && n_rise == r0, "R5", (txn - t0) + (n_rise - r0), 0);
        end
        run_cmd(1'b0, 8'd7, 8'h00, init_val(7), 2, 1, 39, "R5");

        // R6: missing acknowledge at each written byte
        nack_at = 0;
        run_cmd(1'b0, 8'd9, 8'h00, 8'h21, 1, 1, 11, "R6");
        nack_at = 1;
        run_cmd(1'b0, 8'd9, 8'h00, 8'h21, 1, 1, 20, "R6");
        nack_at = 2;
        run_cmd(1'b1, 8'd40, 8'hA5, 8'h21, 1, 1, 29, "R6");
        chk(mem[40] == init_val(40), "R6", int'(mem[40]), int'(init_val(40)));
        nack_at = 0;
        run_cmd(1'b1, 8'd41, 8'h5A, 8'h21, 1, 1, 11, "R6");
        nack_at = -1;
        run_cmd(1'b0, 8'd9, 8'h00, init_val(9), 2, 1, 39, "R6");

        // R9: next header accepted in the cycle the previous reply is taken
        begin
          int t0;
          stall = 1;
          t0 = txn;
          send_byte(8'h52); send_byte(8'd5);
          send_byte(8'h52); send_byte(8'd250);
          while (txn < t0 + 4) @(negedge clk);
          repeat (6) @(negedge clk);
          chk(txn == t0 + 4, "R9", txn - t0, 4);
          chk(txbuf[t0]   == 8'h72, "R9", int'(txbuf[t0]), 8'h72);
          chk(txbuf[t0+1] == init_val(5), "R9", int'(txbuf[t0+1]), int'(init_val(5)));
          chk(txbuf[t0+2] == 8'h72, "R9", int'(txbuf[t0+2]), 8'h72);
          chk(txbuf[t0+3] == init_val(250), "R9", int'(txbuf[t0+3]), int'(init_val(250)));
          stall = 0;
        end

        // R8: SCL high and low widths within a byte
        chk(min_hi == 2 * DIV, "R8", min_hi, 2 * DIV);
        chk(min_lo == 2 * DIV, "R8", min_lo, 2 * DIV);
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;

    if (timed_out) begin
      tests++;
      fails++;
      $display("FAIL R9 watchdog actual=%0d cycles expected fewer than %0d", 150000, 150000);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule